// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block is the mode sequencer for a digital phase-locked loop. Each clock it takes a small set of status flags and turns them into one of six operating modes. The flags say whether an input clock is selected and qualified, whether fast loss has been seen, whether the loop reports lock, and whether a one-second tick has arrived. From the mode it derives whether the loop is closed and holds a lock status. It also picks which of three programmed bandwidth/damping code pairs drives the loop filter: starting, acquisition or locked.

Switching runs in one of two regimes. In automatic control the controller acquires an input and locks to it by itself, and falls back to holdover when the input is lost. In external control the automatic steps stop. A forced-mode request then places the controller in any legal mode, and a clock-switch event or a missing qualified input parks a locked loop in temporary holdover. Each lock attempt opens a starting window that lasts for two one-second ticks and then gives way to acquisition codes.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the mode is Free-Run, lock status is 0, the loop is open and the starting codes are output.
- R2: Mode codes are Free-Run=0, Pre-Locked=1, Locked=2, Temp-Holdover=3, Lost-Phase=4, Holdover=5. No other code ever appears. `loopClosed` is 1 only when the mode is 1 to 4 and `inputSel` is 1.
- R3: Under automatic control, Free-Run or Holdover with `inputSel`=1 moves to Pre-Locked on the next edge. Pre-Locked with `lockInd`=1 moves to Locked.
- R4: In Locked, `fastLoss`=1 with `fastLossSw`=1 clears lock status on the next edge. Under automatic control the mode also moves to Lost-Phase, and Lost-Phase returns to Locked when `lockInd`=1. Under external control the mode stays Locked until `lockInd` sets the status again.
- R5: In Locked, `fastLoss`=1 with `fastLossSw`=0 moves to Temp-Holdover and keeps lock status at its value.
- R6: Under external control, Locked moves to Temp-Holdover on `clkSwitch`=1 or `qualAvail`=0. In either regime, Temp-Holdover returns to Locked when `inputSel`=1, `qualAvail`=1 and `fastLoss`=0.
- R7: Under automatic control with `inputSel`=0, Locked, Temp-Holdover and Lost-Phase move to Holdover, and Pre-Locked moves to Free-Run.
- R8: With `extCtrl`=1 and `forceReq`=1, a `forceMode` value of 0 to 5 becomes the mode on the next edge, ahead of every other rule. Values 6 and 7 are ignored, and so is any request made under automatic control.
- R9: A seconds count restarts at 0 on each entry into Pre-Locked or Lost-Phase, and otherwise counts `secTick` pulses up to 2. With lock status 0, the starting codes are output while the count is below 2 and the acquisition codes after that. With lock status 1, the locked codes are output.
- R10: With `lockedOnly`=1, the locked bandwidth and damping codes are output in every stage.
- R11: Lock status is set on entry into Locked, is held in Temp-Holdover, and is 0 in Free-Run, Pre-Locked, Lost-Phase and Holdover.
- R12: Under external control, without a forced request, Free-Run, Holdover, Pre-Locked and Lost-Phase keep their mode whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inputSel | input | 1 | An input clock is selected |
| qualAvail | input | 1 | A qualified input is available |
| fastLoss | input | 1 | Fast-loss flag of the selected input |
| fastLossSw | input | 1 | 1: fast loss unlocks the loop; 0: fast loss enters temporary holdover |
| lockInd | input | 1 | Lock indication from the phase detector |
| extCtrl | input | 1 | 1: external mode control; 0: automatic |
| clkSwitch | input | 1 | Selected-input switch event |
| secTick | input | 1 | One-second tick pulse |
| forceReq | input | 1 | Forced-mode request |
| forceMode | input | 3 | Requested mode code |
| lockedOnly | input | 1 | Always use the locked codes |
| startBw | input | 5 | Starting bandwidth code |
| startDamp | input | 3 | Starting damping code |
| acqBw | input | 5 | Acquisition bandwidth code |
| acqDamp | input | 3 | Acquisition damping code |
| lockBw | input | 5 | Locked bandwidth code |
| lockDamp | input | 3 | Locked damping code |
| mode | output | 3 | Current operating mode |
| loopClosed | output | 1 | Loop closed |
| bwCode | output | 5 | Active bandwidth code |
| dampCode | output | 3 | Active damping code |
| lockedStat | output | 1 | Lock status |

## Verification
The hardest state to reach from the ports is external control with the mode still Locked and the lock status already cleared by a fast loss. To get there, the bench first locks under automatic control. It then switches to external control, forces Locked, and raises fast loss with the switch bit set. The bench then checks that the status comes back only on a fresh lock indication. The starting window is reached by re-entering Lost-Phase after the count has saturated, which shows that the count restarts. A long stretch of random flags then drives every transition against a behavioural model that is compared on every clock.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FREE = 3'd0,
    MODE_PRE  = 3'd1,
    MODE_LOCK = 3'd2,
    MODE_TEMP = 3'd3,
    MODE_LOST = 3'd4,
    MODE_HOLD = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    STAGE_START = 2'd0,
    STAGE_ACQ   = 2'd1,
    STAGE_LOCK  = 2'd2
  } stage_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restartWin;
    logic lockedStat;
    logic closedMode;
  } ctl_t;
endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inputSel,
  input  logic              qualAvail,
  input  logic              fastLoss,
  input  logic              fastLossSw,
  input  logic              lockInd,
  input  logic              extCtrl,
  input  logic              clkSwitch,
  input  logic              forceReq,
  input  logic [MODE_W-1:0] forceMode,
  output mode_e             modeQ,
  output ctl_t              ctl
);
  mode_e modeD;
  logic  statQ, statD;
  logic  autoCtl, forceOk;

  assign autoCtl = !extCtrl;
  assign forceOk = extCtrl && forceReq && (forceMode <= MODE_W'(MODE_HOLD));

  always_comb begin
    modeD = modeQ;
    if (forceOk) begin
      modeD = mode_e'(forceMode);
    end else begin
      unique case (modeQ)
        MODE_FREE, MODE_HOLD:
          if (autoCtl && inputSel) modeD = MODE_PRE;
        MODE_PRE:
          if (autoCtl && !inputSel)  modeD = MODE_FREE;
          else if (autoCtl && lockInd) modeD = MODE_LOCK;
        MODE_LOCK:
          if (fastLoss && fastLossSw) begin
            if (autoCtl) modeD = MODE_LOST;
          end else if (fastLoss) begin
            modeD = MODE_TEMP;
          end else if (extCtrl && (clkSwitch || !qualAvail)) begin
            modeD = MODE_TEMP;
          end else if (autoCtl && !inputSel) begin
            modeD = MODE_HOLD;
          end
        MODE_TEMP:
          if (inputSel && qualAvail && !fastLoss) modeD = MODE_LOCK;
          else if (autoCtl && !inputSel)          modeD = MODE_HOLD;
        MODE_LOST:
          if (autoCtl && !inputSel)     modeD = MODE_HOLD;
          else if (autoCtl && lockInd)  modeD = MODE_LOCK;
        default: modeD = MODE_FREE;
      endcase
    end
  end

  always_comb begin
    statD = 1'b0;
    if (modeD == MODE_LOCK) begin
      if (modeQ == MODE_LOCK && fastLoss && fastLossSw && !forceOk) statD = 1'b0;
      else if (modeQ != MODE_LOCK || lockInd)                        statD = 1'b1;
      else                                                            statD = statQ;
    end else if (modeD == MODE_TEMP) begin
      statD = statQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_FREE;
      statQ <= 1'b0;
    end else begin
      modeQ <= modeD;
      statQ <= statD;
    end
  end

  assign ctl.restartWin = (modeD == MODE_PRE || modeD == MODE_LOST) && (modeD != modeQ);
  assign ctl.lockedStat = statQ;
  assign ctl.closedMode = (modeQ == MODE_PRE) || (modeQ == MODE_LOCK) ||
                          (modeQ == MODE_TEMP) || (modeQ == MODE_LOST);
endmodule

// File: rtl/dpll_mode_dp.sv
module dpll_mode_dp
  import dpll_mode_pkg::*;
#(
  parameter int BW_W       = 5,
  parameter int DAMP_W     = 3,
  parameter int START_SECS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic              inputSel,
  input  logic              secTick,
  input  logic              lockedOnly,
  input  logic [BW_W-1:0]   startBw,
  input  logic [DAMP_W-1:0] startDamp,
  input  logic [BW_W-1:0]   acqBw,
  input  logic [DAMP_W-1:0] acqDamp,
  input  logic [BW_W-1:0]   lockBw,
  input  logic [DAMP_W-1:0] lockDamp,
  output logic              loopClosed,
  output logic [BW_W-1:0]   bwCode,
  output logic [DAMP_W-1:0] dampCode
);
  localparam int CNT_W = $clog2(START_SECS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(START_SECS);

  logic [CNT_W-1:0] secCnt;
  stage_e           stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          secCnt <= '0;
    else if (ctl.restartWin)            secCnt <= '0;
    else if (secTick && secCnt < CNT_MAX) secCnt <= secCnt + 1'b1;
  end

  always_comb begin
    if (lockedOnly || ctl.lockedStat) stage = STAGE_LOCK;
    else if (secCnt < CNT_MAX)         stage = STAGE_START;
    else                               stage = STAGE_ACQ;
  end

  always_comb begin
    unique case (stage)
      STAGE_START: begin bwCode = startBw; dampCode = startDamp; end
      STAGE_ACQ:   begin bwCode = acqBw;   dampCode = acqDamp;   end
      default:     begin bwCode = lockBw;  dampCode = lockDamp;  end
    endcase
  end

  assign loopClosed = ctl.closedMode && inputSel;
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int BW_W       = 5,
  parameter int DAMP_W     = 3,
  parameter int START_SECS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inputSel,
  input  logic              qualAvail,
  input  logic              fastLoss,
  input  logic              fastLossSw,
  input  logic              lockInd,
  input  logic              extCtrl,
  input  logic              clkSwitch,
  input  logic              secTick,
  input  logic              forceReq,
  input  logic [2:0]        forceMode,
  input  logic              lockedOnly,
  input  logic [BW_W-1:0]   startBw,
  input  logic [DAMP_W-1:0] startDamp,
  input  logic [BW_W-1:0]   acqBw,
  input  logic [DAMP_W-1:0] acqDamp,
  input  logic [BW_W-1:0]   lockBw,
  input  logic [DAMP_W-1:0] lockDamp,
  output logic [2:0]        mode,
  output logic              loopClosed,
  output logic [BW_W-1:0]   bwCode,
  output logic [DAMP_W-1:0] dampCode,
  output logic              lockedStat
);
  mode_e modeQ;
  ctl_t  ctl;

  dpll_mode_fsm uFsm (
    .clk(clk), .rstN(rstN), .inputSel(inputSel), .qualAvail(qualAvail),
    .fastLoss(fastLoss), .fastLossSw(fastLossSw), .lockInd(lockInd),
    .extCtrl(extCtrl), .clkSwitch(clkSwitch), .forceReq(forceReq),
    .forceMode(forceMode), .modeQ(modeQ), .ctl(ctl)
  );

  dpll_mode_dp #(.BW_W(BW_W), .DAMP_W(DAMP_W), .START_SECS(START_SECS)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inputSel(inputSel), .secTick(secTick),
    .lockedOnly(lockedOnly), .startBw(startBw), .startDamp(startDamp),
    .acqBw(acqBw), .acqDamp(acqDamp), .lockBw(lockBw), .lockDamp(lockDamp),
    .loopClosed(loopClosed), .bwCode(bwCode), .dampCode(dampCode)
  );

  assign mode       = modeQ;
  assign lockedStat = ctl.lockedStat;
endmodule

// File: rtl/dpll_mode_chk.sv
module dpll_mode_chk #(
  parameter int BW_W   = 5,
  parameter int DAMP_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inputSel,
  input logic              fastLoss,
  input logic              fastLossSw,
  input logic              extCtrl,
  input logic              forceReq,
  input logic [2:0]        forceMode,
  input logic              lockedOnly,
  input logic [BW_W-1:0]   lockBw,
  input logic [DAMP_W-1:0] lockDamp,
  input logic [2:0]        mode,
  input logic              loopClosed,
  input logic [BW_W-1:0]   bwCode,
  input logic [DAMP_W-1:0] dampCode,
  input logic              lockedStat
);
  logic forcing;
  assign forcing = extCtrl && forceReq;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    mode <= 3'd5); // R2
  AST_OPEN_NO_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    !inputSel |-> !loopClosed); // R2
  AST_FORCE_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (forcing && forceMode <= 3'd5) |=> (mode == $past(forceMode))); // R8
  AST_FAST_LOSS_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2 && fastLoss && fastLossSw && !forcing) |=> !lockedStat); // R4
  AST_FAST_LOSS_TEMP: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2 && fastLoss && !fastLossSw && !forcing) |=> (mode == 3'd3)); // R5
  AST_STAT_MODES: assert property (@(posedge clk) disable iff (!rstN)
    lockedStat |-> (mode == 3'd2 || mode == 3'd3)); // R11
  AST_LOCKED_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    lockedOnly |-> (bwCode == lockBw && dampCode == lockDamp)); // R10
endmodule

bind dpll_mode_ctrl dpll_mode_chk #(.BW_W(BW_W), .DAMP_W(DAMP_W)) uChk (
  .clk(clk), .rstN(rstN), .inputSel(inputSel), .fastLoss(fastLoss),
  .fastLossSw(fastLossSw), .extCtrl(extCtrl), .forceReq(forceReq),
  .forceMode(forceMode), .lockedOnly(lockedOnly), .lockBw(lockBw),
  .lockDamp(lockDamp), .mode(mode), .loopClosed(loopClosed),
  .bwCode(bwCode), .dampCode(dampCode), .lockedStat(lockedStat)
);

// File: tb/tb_dpll_mode_ctrl.sv
`timescale 1ns/1ps
module tb_dpll_mode_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inputSel = 0, qualAvail = 1, fastLoss = 0, fastLossSw = 0, lockInd = 0;
  logic extCtrl = 0, clkSwitch = 0, secTick = 0, forceReq = 0, lockedOnly = 0;
  logic [2:0] forceMode = 0;
  logic [4:0] startBw = 5'd3, acqBw = 5'd9, lockBw = 5'd20;
  logic [2:0] startDamp = 3'd1, acqDamp = 3'd2, lockDamp = 3'd5;
  logic [2:0] mode;
  logic loopClosed, lockedStat;
  logic [4:0] bwCode;
  logic [2:0] dampCode;

  int checks = 0, fails = 0, cycles = 0;
  int mMode = 0, mCnt = 0;
  bit mStat = 0;

  always #4 clk = ~clk;

  dpll_mode_ctrl dut (.*);

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mStat = 0; mCnt = 0;
    end else begin
      int nm; bit ns; bit forced;
      nm = mMode;
      forced = extCtrl && forceReq && forceMode < 6;
      if (forced) nm = forceMode;
      else if (!extCtrl) begin
        if ((mMode == 0 || mMode == 5) && inputSel) nm = 1;
        else if (mMode == 1) nm = !inputSel ? 0 : (lockInd ? 2 : 1);
        else if (mMode == 2) begin
          if (fastLoss) nm = fastLossSw ? 4 : 3;
          else if (!inputSel) nm = 5;
        end
        else if (mMode == 3) nm = (inputSel && qualAvail && !fastLoss) ? 2 : (!inputSel ? 5 : 3);
        else if (mMode == 4) nm = !inputSel ? 5 : (lockInd ? 2 : 4);
      end else begin
        if (mMode == 2) begin
          if (fastLoss && !fastLossSw) nm = 3;
          else if (!fastLoss && (clkSwitch || !qualAvail)) nm = 3;
        end
        else if (mMode == 3 && inputSel && qualAvail && !fastLoss) nm = 2;
      end
      if (nm == 2) begin
        if (mMode == 2 && fastLoss && fastLossSw && !forced) ns = 0;
        else if (mMode != 2 || lockInd) ns = 1;
        else ns = mStat;
      end else if (nm == 3) ns = mStat;
      else ns = 0;
      if ((nm == 1 || nm == 4) && nm != mMode) mCnt = 0;
      else if (secTick && mCnt < 2) mCnt++;
      mMode = nm; mStat = ns;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    int eBw, eDamp;
    cycles++;
    if ((lockedOnly || mStat)) begin eBw = lockBw; eDamp = lockDamp; end
    else if (mCnt < 2) begin eBw = startBw; eDamp = startDamp; end
    else begin eBw = acqBw; eDamp = acqDamp; end
    check("R2 mode", mode, mMode);
    check("R2 loopClosed", loopClosed, (mMode >= 1 && mMode <= 4 && inputSel) ? 1 : 0);
    check("R11 lockedStat", lockedStat, mStat);
    check("R9 bwCode", bwCode, eBw);
    check("R9 dampCode", dampCode, eDamp);
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic at(input string tag, input int expMode, input int expStat, input int expBw);
    @(negedge clk);
    check({tag, " mode"}, mode, expMode);
    check({tag, " stat"}, lockedStat, expStat);
    check({tag, " bw"}, bwCode, expBw);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 100000) begin
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    finishRun();
  end

  initial begin
    cyc(3);
    at("R1", 0, 0, 3);
    check("R1 loopClosed", loopClosed, 0);
    rstN = 1; cyc(1);
    at("R1", 0, 0, 3);
    inputSel = 1; cyc(1); at("R3", 1, 0, 3);
    check("R2 closed", loopClosed, 1);
    secTick = 1; cyc(1); secTick = 0; at("R9", 1, 0, 3);
    secTick = 1; cyc(1); secTick = 0; at("R9", 1, 0, 9);
    lockInd = 1; cyc(1); lockInd = 0; at("R3", 2, 1, 20);
    fastLossSw = 1; fastLoss = 1; cyc(1); fastLoss = 0; at("R4", 4, 0, 3);
    lockInd = 1; cyc(1); lockInd = 0; at("R4", 2, 1, 20);
    fastLossSw = 0; fastLoss = 1; cyc(1); at("R5", 3, 1, 20);
    fastLoss = 0; cyc(1); at("R6", 2, 1, 20);
    inputSel = 0; cyc(1); at("R7", 5, 0, 3);
    check("R2 open", loopClosed, 0);
    inputSel = 1; cyc(1); at("R3", 1, 0, 3);
    inputSel = 0; cyc(1); at("R7", 0, 0, 3);
    lockedOnly = 1; at("R10", 0, 0, 20);
    check("R10 damp", dampCode, 5);
    lockedOnly = 0;
    forceReq = 1; forceMode = 2; cyc(1); at("R8", 0, 0, 3);
    extCtrl = 1; cyc(1); forceReq = 0; at("R8", 2, 1, 20);
    inputSel = 1;
    clkSwitch = 1; cyc(1); clkSwitch = 0; at("R6", 3, 1, 20);
    cyc(1); at("R6", 2, 1, 20);
    qualAvail = 0; cyc(1); qualAvail = 1; at("R6", 3, 1, 20);
    cyc(1); at("R6", 2, 1, 20);
    fastLossSw = 1; fastLoss = 1; cyc(1); fastLoss = 0; at("R4", 2, 0, 3);
    cyc(1); at("R4", 2, 0, 3);
    lockInd = 1; cyc(1); lockInd = 0; at("R11", 2, 1, 20);
    forceReq = 1; forceMode = 6; cyc(1); at("R8", 2, 1, 20);
    forceMode = 4; cyc(1); forceReq = 0; at("R8", 4, 0, 3);
    lockInd = 1; cyc(1); lockInd = 0; at("R12", 4, 0, 3);
    forceReq = 1; forceMode = 0; cyc(1); forceReq = 0;
    inputSel = 1; cyc(1); at("R12", 0, 0, 3);
    // random stress against the reference model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      inputSel   = (r % 8) != 0;
      qualAvail  = ((r >> 3) % 6) != 0;
      fastLoss   = ((r >> 6) % 9) == 0;
      fastLossSw = r[9];
      lockInd    = ((r >> 10) % 4) == 0;
      extCtrl    = ((r >> 12) % 64) < 20 ? ~extCtrl : extCtrl;
      clkSwitch  = ((r >> 18) % 10) == 0;
      secTick    = ((r >> 22) % 3) == 0;
      forceReq   = ((r >> 24) % 12) == 0;
      forceMode  = r[29:27];
      lockedOnly = ((r >> 30) % 2 == 1) && (i % 7 == 0);
      if (i % 50 == 0) begin
        startBw = 5'($urandom); acqBw = 5'($urandom); lockBw = 5'($urandom);
        startDamp = 3'($urandom); acqDamp = 3'($urandom); lockDamp = 3'($urandom);
      end
      cyc(1);
    end
    @(negedge clk);
    finishRun();
  end
endmodule